// File: doc/BRIEF.md
# Four-Channel Shared-Counter PWM Generator

This block produces four pulse-width-modulated lines from a single timebase. A power-of-two prescaler slows the input clock into counter steps. A shared counter then runs either upward only, which gives edge-aligned pulses, or upward then downward, which gives center-aligned pulses. Each channel compares the counter with its own duty value. A one-cycle strobe marks the end of every PWM period.

Software or a neighbouring block writes the period length (top value), the per-channel duty values, the prescaler code and the counting mode through simple single-cycle load strobes. Every written value first lands in a shadow register. All shadow values move together into the active set at a period boundary, so the waveform never changes in the middle of a period.

An enable input freezes and resumes the whole timebase, and the output levels are kept while it is frozen. The counter is a state machine with the states `ST_IDLE`, `ST_UP` and `ST_DOWN`, which are linked by these transitions:

- T_START: `ST_IDLE` to `ST_UP` on the first enable after reset. The shadow values are loaded and the counter is cleared.
- T_WRAP_EDGE: `ST_UP` to `ST_UP` in up mode at count top-1. The counter wraps to 0 and the shadow values are loaded.
- T_TURN: `ST_UP` to `ST_DOWN` in up-and-down mode at count top-1. The counter steps to top.
- T_WRAP_CENTER: `ST_DOWN` to `ST_UP` at count 1. The counter steps to 0 and the shadow values are loaded.

Top module: `pwm_quad_gen`

## Requirements
- R1: After reset the active top value is 1000, the prescaler divides by 16, the counter runs up only, all duty values are 0, and all outputs and the period strobe are low. Once enabled, the first period lasts 16000 clock cycles.
- R2: Prescaler code n (0..7) on `cfg_div` makes the counter step once every 2^n clock cycles. An up-mode period therefore lasts top*2^n cycles.
- R3: With `cfg_center`=0 the counter steps 0,1,...,top-1 and wraps. A channel with duty d (1 <= d < top) is high for d*2^n cycles of each period.
- R4: With `cfg_center`=1 the counter steps 0 up to top and back down to 1, so a period lasts 2*top*2^n cycles. A channel with duty d (1 <= d < top) is high for (2d-1)*2^n cycles of it.
- R5: A top write above 32767 (bit 15 of `top_val` set) is stored as 32767. A top write of 0 is stored as 1.
- R6: A duty write keeps only bits 14:0 of `cmp_val`; bit 15 is dropped. `cmp_idx` selects the channel (0..3, matching bit positions of `pwm_out`).
- R7: A duty value of 0 holds its output low for the whole period. A duty value at or above the active top holds it high for the whole period.
- R8: Writes go to shadow registers. All shadow values become active together only at a period boundary, or at T_START. A write sampled on the boundary edge itself lands after the copy, so it takes effect one period later.
- R9: While `enable` is low, the counter and prescaler freeze, each output keeps its level and no period strobe is produced. Raising `enable` resumes from the frozen count.
- R10: `period_end` is high for exactly one cycle per period: the first cycle in which the counter is back at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Run (1) or freeze (0) the timebase |
| cfg_wr | input | 1 | Load strobe for prescaler code and counting mode |
| cfg_div | input | 3 | Prescaler code, divide by 2^code |
| cfg_center | input | 1 | 1 = up-and-down counting, 0 = up only |
| top_wr | input | 1 | Load strobe for the top value |
| top_val | input | 16 | Top value, saturated to 15 bits |
| cmp_wr | input | 1 | Load strobe for one duty value |
| cmp_idx | input | 2 | Channel selected by `cmp_wr` |
| cmp_val | input | 16 | Duty value, low 15 bits kept |
| pwm_out | output | 4 | PWM lines, bit i is channel i |
| period_end | output | 1 | One-cycle strobe at each period start |

## Verification
The two functions that can fall in one cycle are a duty write and the shadow-to-active copy at a period boundary. The bench counts the cycles of a known period and raises `cmp_wr` on the cycle just before `period_end` is due, so that the write is sampled on the very edge that wraps the counter. It then measures the high time over the next two whole periods. The period that follows must still show the previous shadow value, and only the period after it may show the newly written duty.

// File: rtl/pwm_quad_pkg.sv
package pwm_quad_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_UP   = 2'd1,
        ST_DOWN = 2'd2
    } cnt_state_e;

endpackage

// File: rtl/pwm_prescaler.sv
module pwm_prescaler #(
    parameter int DIV_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div_code,
    output logic             tick
);
    localparam int PRE_W = (1 << DIV_W) - 1;
    localparam logic [DIV_W-1:0] MAX_CODE = DIV_W'(PRE_W);

    logic [PRE_W-1:0] pre_cnt;
    logic [PRE_W-1:0] limit;

    // Terminal count is 2^code - 1, built by shifting an all-ones word.
    assign limit = {PRE_W{1'b1}} >> (MAX_CODE - div_code);
    assign tick  = run && (pre_cnt == limit);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_cnt <= '0;
        end else if (tick) begin
            pre_cnt <= '0;
        end else if (run) begin
            pre_cnt <= pre_cnt + 1'b1;
        end
    end

    AST_PRE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        pre_cnt <= limit); // R2

endmodule

// File: rtl/pwm_shadow_regs.sv
module pwm_shadow_regs #(
    parameter int NUM_CH  = 4,
    parameter int VAL_W   = 15,
    parameter int DIV_W   = 3,
    parameter int TOP_RST = 1000,
    parameter int DIV_RST = 4,
    parameter int SEL_W   = 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          cfg_wr,
    input  logic [DIV_W-1:0]              cfg_div,
    input  logic                          cfg_center,
    input  logic                          top_wr,
    input  logic [VAL_W:0]                top_val,
    input  logic                          cmp_wr,
    input  logic [SEL_W-1:0]              cmp_idx,
    input  logic [VAL_W:0]                cmp_val,
    input  logic                          load,
    output logic [VAL_W-1:0]              act_top,
    output logic [DIV_W-1:0]              act_div,
    output logic                          act_center,
    output logic [NUM_CH-1:0][VAL_W-1:0]  act_cmp
);
    localparam logic [VAL_W-1:0] TOP_MAX  = {VAL_W{1'b1}};
    localparam logic [VAL_W-1:0] TOP_MIN  = {{(VAL_W-1){1'b0}}, 1'b1};
    localparam logic [VAL_W:0]   CMP_MASK = {1'b0, {VAL_W{1'b1}}};

    logic [VAL_W-1:0]             sh_top;
    logic [DIV_W-1:0]             sh_div;
    logic                         sh_center;
    logic [NUM_CH-1:0][VAL_W-1:0] sh_cmp;
    logic [VAL_W-1:0]             top_sat;

    // Clamp the written top into [1, 2^VAL_W - 1].
    always_comb begin
        if (top_val[VAL_W]) begin
            top_sat = TOP_MAX;
        end else if (top_val[VAL_W-1:0] == '0) begin
            top_sat = TOP_MIN;
        end else begin
            top_sat = top_val[VAL_W-1:0];
        end
    end

    // Shadow side: written by the load strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_top    <= VAL_W'(TOP_RST);
            sh_div    <= DIV_W'(DIV_RST);
            sh_center <= 1'b0;
        end else begin
            if (top_wr) begin
                sh_top <= top_sat;
            end
            if (cfg_wr) begin
                sh_div    <= cfg_div;
                sh_center <= cfg_center;
            end
        end
    end

    generate
        for (genvar g = 0; g < NUM_CH; g++) begin : g_sh_cmp
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    sh_cmp[g] <= '0;
                end else if (cmp_wr && (cmp_idx == SEL_W'(g))) begin
                    sh_cmp[g] <= cmp_val[VAL_W-1:0];
                end
            end
        end
    endgenerate

    // Active side: copied as one set on the boundary pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_top    <= VAL_W'(TOP_RST);
            act_div    <= DIV_W'(DIV_RST);
            act_center <= 1'b0;
            act_cmp    <= '0;
        end else if (load) begin
            act_top    <= sh_top;
            act_div    <= sh_div;
            act_center <= sh_center;
            act_cmp    <= sh_cmp;
        end
    end

    AST_TOP_SATURATES: assert property (@(posedge clk) disable iff (!rst_n)
        top_wr && top_val[VAL_W] |=> sh_top == TOP_MAX); // R5

    AST_CMP_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_wr |=> {1'b0, sh_cmp[$past(cmp_idx)]} == ($past(cmp_val) & CMP_MASK)); // R6

    AST_ACTIVE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(act_cmp) && $stable(act_top) && $stable(act_div)); // R8

endmodule

// File: rtl/pwm_count_fsm.sv
module pwm_count_fsm
    import pwm_quad_pkg::*;
#(
    parameter int VAL_W = 15
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             tick,
    input  logic [VAL_W-1:0] act_top,
    input  logic             act_center,
    output logic             run,
    output logic             load,
    output logic [VAL_W-1:0] cnt,
    output logic             period_end
);
    localparam logic [VAL_W-1:0] ONE = {{(VAL_W-1){1'b0}}, 1'b1};

    cnt_state_e       state_q, state_d;
    logic [VAL_W-1:0] cnt_q, cnt_d;
    logic             wrap, start;
    logic             pend_q;

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // Next state and next count.
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        wrap    = 1'b0;
        start   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (enable) begin           // T_START
                    state_d = ST_UP;
                    cnt_d   = '0;
                    start   = 1'b1;
                end
            end
            ST_UP: begin
                if (tick) begin
                    if (cnt_q == act_top - ONE) begin
                        if (act_center) begin   // T_TURN
                            state_d = ST_DOWN;
                            cnt_d   = act_top;
                        end else begin          // T_WRAP_EDGE
                            cnt_d = '0;
                            wrap  = 1'b1;
                        end
                    end else begin
                        cnt_d = cnt_q + ONE;
                    end
                end
            end
            ST_DOWN: begin
                if (tick) begin
                    if (cnt_q == ONE) begin     // T_WRAP_CENTER
                        state_d = ST_UP;
                        cnt_d   = '0;
                        wrap    = 1'b1;
                    end else begin
                        cnt_d = cnt_q - ONE;
                    end
                end
            end
            default: begin
                state_d = ST_IDLE;
                cnt_d   = '0;
            end
        endcase
    end

    // Outputs.
    assign run  = enable && (state_q != ST_IDLE);
    assign load = start || wrap;
    assign cnt  = cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
        end else begin
            pend_q <= wrap;
        end
    end

    assign period_end = pend_q;

    AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= act_top); // R4

    AST_EDGE_NEVER_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        !act_center |-> state_q != ST_DOWN); // R3

    AST_PEND_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        pend_q |-> cnt_q == '0); // R10

endmodule

// File: rtl/pwm_channel_out.sv
module pwm_channel_out #(
    parameter int VAL_W = 15
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [VAL_W-1:0] cnt,
    input  logic [VAL_W-1:0] cmp,
    input  logic [VAL_W-1:0] top,
    output logic             out
);
    logic level;
    logic out_q;

    assign level = (cnt < cmp) || (cmp >= top);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= 1'b0;
        end else if (run) begin
            out_q <= level;
        end
    end

    assign out = out_q;

endmodule

// File: rtl/pwm_quad_gen.sv
module pwm_quad_gen
    import pwm_quad_pkg::*;
#(
    parameter int NUM_CH  = 4,
    parameter int VAL_W   = 15,
    parameter int DIV_W   = 3,
    parameter int TOP_RST = 1000,
    parameter int DIV_RST = 4,
    parameter int SEL_W   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              cfg_wr,
    input  logic [DIV_W-1:0]  cfg_div,
    input  logic              cfg_center,
    input  logic              top_wr,
    input  logic [VAL_W:0]    top_val,
    input  logic              cmp_wr,
    input  logic [SEL_W-1:0]  cmp_idx,
    input  logic [VAL_W:0]    cmp_val,
    output logic [NUM_CH-1:0] pwm_out,
    output logic              period_end
);
    logic [VAL_W-1:0]             act_top;
    logic [DIV_W-1:0]             act_div;
    logic                         act_center;
    logic [NUM_CH-1:0][VAL_W-1:0] act_cmp;
    logic                         run, load, tick;
    logic [VAL_W-1:0]             cnt;

    pwm_shadow_regs #(
        .NUM_CH (NUM_CH),
        .VAL_W  (VAL_W),
        .DIV_W  (DIV_W),
        .TOP_RST(TOP_RST),
        .DIV_RST(DIV_RST),
        .SEL_W  (SEL_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_wr    (cfg_wr),
        .cfg_div   (cfg_div),
        .cfg_center(cfg_center),
        .top_wr    (top_wr),
        .top_val   (top_val),
        .cmp_wr    (cmp_wr),
        .cmp_idx   (cmp_idx),
        .cmp_val   (cmp_val),
        .load      (load),
        .act_top   (act_top),
        .act_div   (act_div),
        .act_center(act_center),
        .act_cmp   (act_cmp)
    );

    pwm_prescaler #(.DIV_W(DIV_W)) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .div_code(act_div),
        .tick    (tick)
    );

    pwm_count_fsm #(.VAL_W(VAL_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (enable),
        .tick      (tick),
        .act_top   (act_top),
        .act_center(act_center),
        .run       (run),
        .load      (load),
        .cnt       (cnt),
        .period_end(period_end)
    );

    generate
        for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
            pwm_channel_out #(.VAL_W(VAL_W)) u_ch (
                .clk  (clk),
                .rst_n(rst_n),
                .run  (run),
                .cnt  (cnt),
                .cmp  (act_cmp[c]),
                .top  (act_top),
                .out  (pwm_out[c])
            );
        end
    endgenerate

    AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> $stable(pwm_out)); // R9

    AST_PEND_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        period_end |-> $past(enable)); // R10

endmodule

// File: tb/pwm_quad_gen_tb_top.sv
`timescale 1ns/1ps
module pwm_quad_gen_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [2:0]  cfg_div = '0;
    logic        cfg_center = 1'b0;
    logic        top_wr = 1'b0;
    logic [15:0] top_val = '0;
    logic        cmp_wr = 1'b0;
    logic [1:0]  cmp_idx = '0;
    logic [15:0] cmp_val = '0;
    logic [3:0]  pwm_out;
    logic        period_end;

    int checks = 0;
    int errors = 0;
    int per_cnt;
    int hi_cnt [4];
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    pwm_quad_gen dut_i (
        .clk(clk), .rst_n(rst_n), .enable(enable),
        .cfg_wr(cfg_wr), .cfg_div(cfg_div), .cfg_center(cfg_center),
        .top_wr(top_wr), .top_val(top_val),
        .cmp_wr(cmp_wr), .cmp_idx(cmp_idx), .cmp_val(cmp_val),
        .pwm_out(pwm_out), .period_end(period_end)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic wr_cfg(input int dv, input bit ctr);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_div = dv[2:0]; cfg_center = ctr;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic wr_top(input int v);
        @(negedge clk);
        top_wr = 1'b1; top_val = v[15:0];
        @(negedge clk);
        top_wr = 1'b0;
    endtask

    task automatic wr_cmp(input int idx, input int v);
        @(negedge clk);
        cmp_wr = 1'b1; cmp_idx = idx[1:0]; cmp_val = v[15:0];
        @(negedge clk);
        cmp_wr = 1'b0;
    endtask

    task automatic wait_pe();
        int guard = 0;
        do begin
            @(negedge clk);
            guard++;
        end while (!period_end && guard < 70000);
        chk(period_end, "R10 period strobe seen", guard, 0);
    endtask

    // Counts from the current strobe cycle to the next one. When inj_at is
    // non-zero, a duty write to channel 0 (and a top write when inj_top is
    // non-zero) is driven at that offset.
    task automatic count_window(input int inj_at, input int inj_cmp, input int inj_top);
        int guard = 0;
        per_cnt = 0;
        for (int i = 0; i < 4; i++) hi_cnt[i] = 0;
        do begin
            @(negedge clk);
            if (cmp_wr || top_wr) begin
                cmp_wr = 1'b0;
                top_wr = 1'b0;
            end
            per_cnt++;
            for (int i = 0; i < 4; i++) if (pwm_out[i]) hi_cnt[i]++;
            if (inj_at != 0 && per_cnt == inj_at) begin
                cmp_wr = 1'b1; cmp_idx = 2'd0; cmp_val = inj_cmp[15:0];
                if (inj_top != 0) begin
                    top_wr = 1'b1; top_val = inj_top[15:0];
                end
            end
            guard++;
        end while (!period_end && guard < 70000);
        if (cmp_wr || top_wr) begin
            @(negedge clk);
            cmp_wr = 1'b0;
            top_wr = 1'b0;
        end
    endtask

    task automatic measure();
        wait_pe();
        count_window(0, 0, 0);
    endtask

    task automatic t_reset();
        bit quiet = 1'b1;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (20) begin
            @(negedge clk);
            if (pwm_out != 4'b0 || period_end) quiet = 1'b0;
        end
        chk(quiet, "R1 outputs low after reset", int'(pwm_out), 0);
        enable = 1'b1;
        measure();
        chk(per_cnt == 16000, "R1 default period", per_cnt, 16000);
        chk(hi_cnt[0] == 0 && hi_cnt[3] == 0, "R1 default duty zero", hi_cnt[0], 0);
    endtask

    task automatic t_saturate();
        wr_cfg(0, 1'b0);
        wr_top(40000);
        measure();
        chk(per_cnt == 32767, "R5 top saturates at 32767", per_cnt, 32767);
        wr_top(0);
        measure();
        chk(per_cnt == 1, "R5 top of zero stored as one", per_cnt, 1);
    endtask

    task automatic t_prescale();
        wr_cfg(2, 1'b0);
        wr_top(10);
        wr_cmp(0, 3);
        measure();
        chk(per_cnt == 40, "R2 divide by 4 period", per_cnt, 40);
        chk(hi_cnt[0] == 12, "R2 divide by 4 duty", hi_cnt[0], 12);
        @(negedge clk);
        chk(!period_end, "R10 strobe lasts one cycle", int'(period_end), 0);
        wr_cfg(7, 1'b0);
        wr_top(3);
        wr_cmp(0, 1);
        measure();
        chk(per_cnt == 384, "R2 divide by 128 period", per_cnt, 384);
        chk(hi_cnt[0] == 128, "R2 divide by 128 duty", hi_cnt[0], 128);
    endtask

    task automatic t_edge();
        wr_cfg(0, 1'b0);
        wr_top(100);
        wr_cmp(0, 30);
        wr_cmp(1, 100);
        wr_cmp(2, 0);
        wr_cmp(3, 32'h8000 + 25);
        measure();
        chk(per_cnt == 100, "R3 edge period", per_cnt, 100);
        chk(hi_cnt[0] == 30, "R3 edge duty", hi_cnt[0], 30);
        chk(hi_cnt[1] == 100, "R7 duty at top always high", hi_cnt[1], 100);
        chk(hi_cnt[2] == 0, "R7 duty zero always low", hi_cnt[2], 0);
        chk(hi_cnt[3] == 25, "R6 duty bit 15 dropped", hi_cnt[3], 25);
    endtask

    task automatic t_center();
        wr_cfg(1, 1'b1);
        wr_top(20);
        wr_cmp(0, 5);
        wr_cmp(1, 0);
        wr_cmp(2, 25);
        wr_cmp(3, 20);
        measure();
        chk(per_cnt == 80, "R4 center period", per_cnt, 80);
        chk(hi_cnt[0] == 18, "R4 center duty", hi_cnt[0], 18);
        chk(hi_cnt[1] == 0, "R7 center duty zero", hi_cnt[1], 0);
        chk(hi_cnt[2] == 80, "R7 center duty above top", hi_cnt[2], 80);
        chk(hi_cnt[3] == 80, "R7 center duty equal top", hi_cnt[3], 80);
    endtask

    task automatic t_double_buffer();
        wr_cfg(0, 1'b0);
        wr_top(100);
        wr_cmp(0, 30);
        measure();
        chk(per_cnt == 100 && hi_cnt[0] == 30, "R8 baseline", hi_cnt[0], 30);
        count_window(50, 70, 120);
        chk(per_cnt == 100, "R8 mid-period top write deferred", per_cnt, 100);
        chk(hi_cnt[0] == 30, "R8 mid-period duty write deferred", hi_cnt[0], 30);
        count_window(119, 10, 0);
        chk(per_cnt == 120 && hi_cnt[0] == 70, "R8 new values after boundary", hi_cnt[0], 70);
        count_window(0, 0, 0);
        chk(hi_cnt[0] == 70, "R8 write on boundary edge waits a period", hi_cnt[0], 70);
        count_window(0, 0, 0);
        chk(hi_cnt[0] == 10, "R8 boundary write lands next period", hi_cnt[0], 10);
    endtask

    task automatic t_hold();
        bit held;
        int guard;
        wr_cmp(0, 50);
        measure();
        chk(per_cnt == 120 && hi_cnt[0] == 50, "R9 setup", hi_cnt[0], 50);
        guard = 0;
        do begin @(negedge clk); guard++; end while (!pwm_out[0] && guard < 500);
        enable = 1'b0;
        held = 1'b1;
        repeat (100) begin
            @(negedge clk);
            if (!pwm_out[0] || period_end) held = 1'b0;
        end
        chk(held, "R9 high level held while disabled", int'(pwm_out[0]), 1);
        enable = 1'b1;
        guard = 0;
        do begin @(negedge clk); guard++; end while (pwm_out[0] && guard < 500);
        enable = 1'b0;
        held = 1'b1;
        repeat (100) begin
            @(negedge clk);
            if (pwm_out[0] || period_end) held = 1'b0;
        end
        chk(held, "R9 low level held while disabled", int'(pwm_out[0]), 0);
        enable = 1'b1;
        measure();
        chk(per_cnt == 120 && hi_cnt[0] == 50, "R9 resumes unchanged", per_cnt, 120);
    endtask

    initial begin
        t_reset();
        t_saturate();
        t_prescale();
        t_edge();
        t_center();
        t_double_buffer();
        t_hold();
        if (!finished) begin
            finished = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (195000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual %0d expected %0d", 195000, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule